// File: doc/BRIEF.md
# Dual-Rail Clock Pulse Error Detector

This block watches a count clock and a redundant copy of it that is supposed to arrive inverted. Each rising edge on the primary rail must be paired with a falling edge on the redundant rail within a short window, and the reverse. An edge left without a partner is a mismatch. The block counts mismatches. When the count reaches a fixed limit, it raises a sticky error flag. A fixed number of system-clock cycles sets the window length, so no timing capacitors are needed.

Both rails are asynchronous to the system clock and pass through synchronizers of equal depth, which keeps the skew between them. A window opens at whichever edge of interest arrives first and closes when the partner edge arrives or when the window runs out. A synchronous master reset clears the count, the flag and any open window. To leave the detector unused, hold the redundant rail at a fixed level and ignore the flag.

Top module: `dual_rail_pulse_check`

## Requirements
- R1: A rising edge on `rail_a` and a falling edge on `rail_b` count no error when the second edge reaches the detector 0 to WINDOW system cycles after the first (default WINDOW = 4), whichever rail leads.
- R2: A rising edge on `rail_a` with no falling edge on `rail_b` inside the window counts one error when the window expires. A falling edge on `rail_b` that comes later opens its own window and counts one more error, so a pair skewed by WINDOW+1 cycles counts two errors.
- R3: A falling edge on `rail_b` with no rising edge on `rail_a` inside the window counts one error.
- R4: A second edge of interest on the same rail while that rail's window is still open counts one error for the earlier edge and opens a new window that starts at the second edge.
- R5: Falling edges on `rail_a` and rising edges on `rail_b` neither count errors nor open windows.
- R6: `err_count` rises by one for each error and saturates at ERR_LIMIT (default 3).
- R7: `err_out` goes high in the cycle `err_count` reaches ERR_LIMIT and stays high until master reset.
- R8: While `mreset` (active high, synchronous) is high, `err_count` goes to 0, `err_out` goes low and any open window closes without counting an error. The rail levels held through reset do not count as edges when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| mreset | input | 1 | Synchronous master reset, active high |
| rail_a | input | 1 | Primary count clock, asynchronous |
| rail_b | input | 1 | Redundant inverted count clock, asynchronous |
| err_out | output | 1 | Sticky flag, high once the error limit is reached |
| err_count | output | $clog2(ERR_LIMIT+1) (2) | Saturating mismatch count |

## Verification
The bench places the second edge exactly WINDOW cycles after the first and then one cycle later. A window that is off by one either misses the legitimate pair or accepts the late one, and the error count shows the difference. It sends repeated rising edges on the primary rail with and without a partner, which exposes a design that drops or double-counts the superseded window. It asserts reset while a window is open, and it holds rails high across reset; a design that lets the open window expire, or that sees the held level as a new edge, counts a spurious error. Random pairs, lone pulses and resets push the count past the limit, which catches a counter that wraps and a flag that is not sticky.

// File: rtl/dual_rail_pkg.sv
package dual_rail_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT_B = 2'd1,
        ST_WAIT_A = 2'd2
    } win_state_e;

endpackage

// File: rtl/dual_rail_sync.sv
module dual_rail_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic mreset,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    // During reset every stage follows the input so no stale level survives.
    always_comb begin
        if (mreset) chain_d = {STAGES{din}};
        else        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk) begin
        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/dual_rail_window.sv
module dual_rail_window
    import dual_rail_pkg::*;
#(
    parameter int WINDOW = 4
) (
    input  logic clk,
    input  logic mreset,
    input  logic lvl_a,
    input  logic lvl_b,
    output logic miss
);
    localparam int TW = $clog2(WINDOW + 1);

    typedef struct packed {
        win_state_e     st;
        logic [TW-1:0]  timer;
        logic           prev_a;
        logic           prev_b;
    } trk_t;

    trk_t trk_d, trk_q;
    logic a_rise, b_fall;

    always_comb begin
        a_rise = lvl_a & ~trk_q.prev_a;
        b_fall = ~lvl_b & trk_q.prev_b;
        trk_d = trk_q;
        trk_d.prev_a = lvl_a;
        trk_d.prev_b = lvl_b;
        miss = 1'b0;
        if (mreset) begin
            trk_d.st = ST_IDLE;
            trk_d.timer = '0;
        end else begin
            unique case (trk_q.st)
                ST_IDLE: begin
                    if (a_rise && !b_fall) begin
                        trk_d.st = ST_WAIT_B;
                        trk_d.timer = TW'(WINDOW);
                    end else if (b_fall && !a_rise) begin
                        trk_d.st = ST_WAIT_A;
                        trk_d.timer = TW'(WINDOW);
                    end
                end
                ST_WAIT_B: begin
                    if (b_fall) begin
                        if (a_rise) begin
                            trk_d.timer = TW'(WINDOW);
                        end else begin
                            trk_d.st = ST_IDLE;
                            trk_d.timer = '0;
                        end
                    end else if (a_rise) begin
                        miss = 1'b1;
                        trk_d.timer = TW'(WINDOW);
                    end else if (trk_q.timer == TW'(1)) begin
                        miss = 1'b1;
                        trk_d.st = ST_IDLE;
                        trk_d.timer = '0;
                    end else begin
                        trk_d.timer = trk_q.timer - 1'b1;
                    end
                end
                ST_WAIT_A: begin
                    if (a_rise) begin
                        if (b_fall) begin
                            trk_d.timer = TW'(WINDOW);
                        end else begin
                            trk_d.st = ST_IDLE;
                            trk_d.timer = '0;
                        end
                    end else if (b_fall) begin
                        miss = 1'b1;
                        trk_d.timer = TW'(WINDOW);
                    end else if (trk_q.timer == TW'(1)) begin
                        miss = 1'b1;
                        trk_d.st = ST_IDLE;
                        trk_d.timer = '0;
                    end else begin
                        trk_d.timer = trk_q.timer - 1'b1;
                    end
                end
                default: begin
                    trk_d.st = ST_IDLE;
                    trk_d.timer = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        trk_q <= trk_d;
    end

    // R2
    timer_live_chk: assert property (@(posedge clk) disable iff (mreset)
        (trk_q.st != ST_IDLE) |-> (trk_q.timer != '0));

    // R8
    pend_clear_chk: assert property (@(posedge clk)
        mreset |=> (trk_q.st == ST_IDLE));
endmodule

// File: rtl/dual_rail_errcnt.sv
module dual_rail_errcnt #(
    parameter int ERR_LIMIT = 3
) (
    input  logic                               clk,
    input  logic                               mreset,
    input  logic                               miss,
    output logic                               err_out,
    output logic [$clog2(ERR_LIMIT+1)-1:0]     err_count
);
    localparam int CW = $clog2(ERR_LIMIT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          flag;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (mreset) begin
            cnt_d.cnt = '0;
            cnt_d.flag = 1'b0;
        end else begin
            if (miss && (cnt_q.cnt < CW'(ERR_LIMIT)))
                cnt_d.cnt = cnt_q.cnt + 1'b1;
            cnt_d.flag = cnt_q.flag | (cnt_d.cnt == CW'(ERR_LIMIT));
        end
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    assign err_out = cnt_q.flag;
    assign err_count = cnt_q.cnt;

    // R6
    cnt_step_chk: assert property (@(posedge clk) disable iff (mreset)
        (cnt_q.cnt != $past(cnt_q.cnt)) |-> (cnt_q.cnt == $past(cnt_q.cnt) + 1'b1));

    // R6
    cnt_cap_chk: assert property (@(posedge clk) disable iff (mreset)
        cnt_q.cnt <= CW'(ERR_LIMIT));

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (mreset)
        cnt_q.flag |=> cnt_q.flag);

    // R7
    flag_match_chk: assert property (@(posedge clk) disable iff (mreset)
        cnt_q.flag == (cnt_q.cnt == CW'(ERR_LIMIT)));

    // R8
    rst_clear_chk: assert property (@(posedge clk)
        mreset |=> (cnt_q.cnt == '0 && !cnt_q.flag));
endmodule

// File: rtl/dual_rail_pulse_check.sv
module dual_rail_pulse_check #(
    parameter int WINDOW      = 4,
    parameter int ERR_LIMIT   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                               clk,
    input  logic                               mreset,
    input  logic                               rail_a,
    input  logic                               rail_b,
    output logic                               err_out,
    output logic [$clog2(ERR_LIMIT+1)-1:0]     err_count
);
    logic [1:0] rail_raw, rail_lvl;
    logic       miss;

    assign rail_raw = {rail_b, rail_a};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        dual_rail_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .mreset (mreset),
            .din    (rail_raw[g]),
            .dout   (rail_lvl[g])
        );
    end

    dual_rail_window #(.WINDOW(WINDOW)) u_window (
        .clk    (clk),
        .mreset (mreset),
        .lvl_a  (rail_lvl[0]),
        .lvl_b  (rail_lvl[1]),
        .miss   (miss)
    );

    dual_rail_errcnt #(.ERR_LIMIT(ERR_LIMIT)) u_errcnt (
        .clk       (clk),
        .mreset    (mreset),
        .miss      (miss),
        .err_out   (err_out),
        .err_count (err_count)
    );
endmodule

// File: tb/dual_rail_pulse_check_test.sv
`timescale 1ns/1ps
module dual_rail_pulse_check_test;
    localparam int WIN = 4;
    localparam int LIM = 3;
    localparam int CW  = $clog2(LIM + 1);

    logic clk = 1'b0;
    logic mreset = 1'b1;
    logic rail_a = 1'b0;
    logic rail_b = 1'b1;
    logic err_out;
    logic [CW-1:0] err_count;

    int n_checks = 0;
    int n_fails = 0;
    int model = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dual_rail_pulse_check #(.WINDOW(WIN), .ERR_LIMIT(LIM), .SYNC_STAGES(2)) uut (
        .clk(clk), .mreset(mreset), .rail_a(rail_a), .rail_b(rail_b),
        .err_out(err_out), .err_count(err_count)
    );

    function automatic int exp_count(int m);
        return (m > LIM) ? LIM : m;
    endfunction

    function automatic bit exp_flag(int m);
        return m >= LIM;
    endfunction

    task automatic check(string req);
        n_checks++;
        if (err_count !== CW'(exp_count(model)) || err_out !== exp_flag(model)) begin
            n_fails++;
            $display("FAIL %s: count=%0d flag=%0b expected count=%0d flag=%0b",
                     req, err_count, err_out, exp_count(model), exp_flag(model));
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    // R5: returning to idle levels is an A fall and a B rise, both ignored
    task automatic restore();
        @(negedge clk);
        rail_a = 1'b0;
        rail_b = 1'b1;
        wait_n(WIN + 8);
        check("R5");
    endtask

    task automatic do_reset();
        @(negedge clk);
        mreset = 1'b1;
        wait_n(2);
        mreset = 1'b0;
        model = 0;
        wait_n(1);
        check("R8");
    endtask

    task automatic pair(bit a_first, int d, string req);
        @(negedge clk);
        if (d == 0) begin
            rail_a = 1'b1;
            rail_b = 1'b0;
        end else begin
            if (a_first) rail_a = 1'b1; else rail_b = 1'b0;
            wait_n(d);
            if (a_first) rail_b = 1'b0; else rail_a = 1'b1;
        end
        wait_n(WIN + 10);
        model += (d > WIN) ? 2 : 0;
        check(req);
        restore();
    endtask

    task automatic lone(bit on_a);
        @(negedge clk);
        if (on_a) rail_a = 1'b1; else rail_b = 1'b0;
        wait_n(WIN + 10);
        model += 1;
        check(on_a ? "R2" : "R3");
        restore();
    endtask

    // R4: two A rises two cycles apart, optionally followed by a B fall
    task automatic double_a(bit with_b);
        @(negedge clk);
        rail_a = 1'b1;
        @(negedge clk);
        rail_a = 1'b0;
        @(negedge clk);
        rail_a = 1'b1;
        if (with_b) begin
            @(negedge clk);
            rail_b = 1'b0;
        end
        wait_n(WIN + 10);
        model += with_b ? 1 : 2;
        check("R4");
        restore();
    endtask

    initial begin
        wait_n(3);
        check("R8");
        mreset = 1'b0;
        wait_n(4);
        check("R8");

        // R1 boundaries on both leads
        pair(1'b1, 0, "R1");
        pair(1'b1, WIN, "R1");
        pair(1'b0, WIN, "R1");
        pair(1'b0, 1, "R1");
        // R2: skew of WIN+1 counts two
        pair(1'b1, WIN + 1, "R2");
        // R3 then R7 at the limit
        lone(1'b0);
        check("R7");
        // R6 saturation, R7 stays high
        lone(1'b1);
        pair(1'b0, WIN + 2, "R6");
        check("R7");
        do_reset();

        // R8: open window cut by reset, level held through reset
        @(negedge clk);
        rail_a = 1'b1;
        wait_n(3);
        mreset = 1'b1;
        @(negedge clk);
        mreset = 1'b0;
        wait_n(WIN + 10);
        check("R8");
        restore();

        // R8: both rails held in active level through reset
        @(negedge clk);
        rail_a = 1'b1;
        rail_b = 1'b0;
        wait_n(WIN + 10);
        mreset = 1'b1;
        wait_n(2);
        mreset = 1'b0;
        wait_n(WIN + 10);
        check("R8");
        restore();

        double_a(1'b1);
        double_a(1'b0);
        check("R7");
        do_reset();

        // Random mix with fixed seed
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 60; i++) begin
            int sel;
            sel = $urandom_range(0, 9);
            case (sel)
                0: do_reset();
                1: lone(1'b1);
                2: lone(1'b0);
                3: double_a($urandom_range(0, 1) == 1);
                default: pair($urandom_range(0, 1) == 1, $urandom_range(0, WIN + 2), "R1");
            endcase
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule